// File: doc/BRIEF.md
# Program ROM Table Read Unit

This block carries out the table-read operation of a small microcontroller core. When the core raises a request, the unit builds a program ROM address, reads one constant word, writes the low byte of that word to a data-memory location named in the request, and latches the high byte into a dedicated table-high register. The core can read that register later.

The upper part of the ROM address comes from one of two places, chosen by a static build option. With the option set, it comes from a high table pointer register. With the option clear, it comes from the upper bits of the current program counter. In both cases the low table pointer supplies the lower byte of the address.

Each access takes two clock cycles. In the fetch cycle, `busy_o` is high and the address is presented to a synchronous ROM. In the write cycle, the data-memory write happens and `done_o` pulses. A new request may be accepted in the write cycle, so accesses can run back to back with one starting every two cycles.

Top module: `tblrd_unit`

## Requirements
- R1: After a synchronous reset, `tbl_hi_o` is zero and `busy_o`, `done_o` and `dm_we_o` are low.
- R2: With `USE_HI_PTR` = 1, the ROM address is `{ptr_hi_i, ptr_lo_i}`, with the low pointer in bits 7:0.
- R3: With `USE_HI_PTR` = 0, the ROM address is `{pc_hi_i, ptr_lo_i}`, where `pc_hi_i` is bits 12:8 of the current program counter.
- R4: The ROM address and destination are captured in the cycle the request is accepted. Later changes on the pointer, PC or destination inputs do not alter an access already in flight.
- R5: `busy_o` is high for exactly the one cycle after acceptance. A request seen while `busy_o` is high is ignored.
- R6: In the second cycle, `done_o` and `dm_we_o` are high for one cycle. `dm_addr_o` equals the captured destination and `dm_wdata_o` equals bits 7:0 of `rom_data_i`.
- R7: `tbl_hi_o` takes bits 15:8 of `rom_data_i` at the end of the done cycle and holds its value at all other times.
- R8: A request present during the done cycle is accepted, so a held request yields one completed access every two cycles.
- R9: While `dm_we_o` is low, `dm_addr_o` and `dm_wdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Table-read request from the core |
| dst_i | input | 8 | Data-memory destination for the low byte |
| ptr_lo_i | input | 8 | Low table pointer |
| ptr_hi_i | input | 5 | High table pointer |
| pc_hi_i | input | 5 | Upper bits of the current program counter |
| rom_addr_o | output | 13 | ROM read address (one-cycle read latency) |
| rom_data_i | input | 16 | ROM read data |
| dm_we_o | output | 1 | Data-memory write enable |
| dm_addr_o | output | 8 | Data-memory write address |
| dm_wdata_o | output | 8 | Data-memory write data |
| tbl_hi_o | output | 8 | Table-high register |
| busy_o | output | 1 | Fetch cycle in progress; requests ignored |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A sequencer stuck in or skipping the fetch state shows at once. `busy_o` and `done_o` go out of step with a model within the same cycle, and the write strobe lands one cycle off. Capture or address-selection faults show as a wrong `rom_addr_o` in the fetch cycle, and then as wrong data-memory write data in the very next cycle. A fault in the table-high register shows on `tbl_hi_o` one cycle after the done strobe, and it persists until the next completed read.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    localparam int TR_PTR_W  = 8;
    localparam int TR_ROM_AW = 13;
    localparam int TR_WORD_W = 16;
    localparam int TR_DM_AW  = 8;
    localparam int TR_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } tr_state_e;

    // accept is allowed in every state except the fetch cycle
    function automatic logic can_accept(input tr_state_e s);
        return s != ST_FETCH;
    endfunction
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
    import tblrd_pkg::*;
#(
    parameter int PTR_W      = TR_PTR_W,
    parameter int ROM_AW     = TR_ROM_AW,
    parameter bit USE_HI_PTR = 1'b1,
    localparam int HI_W      = ROM_AW - PTR_W
) (
    input  logic [PTR_W-1:0]  ptr_lo,
    input  logic [HI_W-1:0]   ptr_hi,
    input  logic [HI_W-1:0]   pc_hi,
    output logic [ROM_AW-1:0] addr
);
    logic [HI_W-1:0] upper;

    always_comb begin
        upper = USE_HI_PTR ? ptr_hi : pc_hi;
        addr  = {upper, ptr_lo};
    end
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic accept,
    output logic busy,
    output logic done
);
    tr_state_e state_q, state_n;

    always_comb begin
        accept  = req && can_accept(state_q);
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  state_n = accept ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_n = ST_WRITE;
            ST_WRITE: state_n = accept ? ST_FETCH : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    assign busy = (state_q == ST_FETCH);
    assign done = (state_q == ST_WRITE);

    // R5: fetch lasts one cycle and is always followed by completion
    a_r5_single_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && done));
    // R6: completion only ever follows a fetch cycle
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

// File: rtl/tblrd_hi_reg.sv
module tblrd_hi_reg
    import tblrd_pkg::*;
#(
    parameter int WORD_W = TR_WORD_W,
    parameter int LO_W   = TR_BYTE_W,
    localparam int HI_W  = WORD_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [HI_W-1:0]   tbl_hi
);
    always_ff @(posedge clk) begin
        if (rst)       tbl_hi <= '0;
        else if (load) tbl_hi <= word[WORD_W-1:LO_W];
    end

    // R7: register moves only at the end of a completion cycle
    a_r7_hold_hi: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tbl_hi));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int PTR_W      = TR_PTR_W,
    parameter int ROM_AW     = TR_ROM_AW,
    parameter int WORD_W     = TR_WORD_W,
    parameter int DM_AW      = TR_DM_AW,
    parameter bit USE_HI_PTR = 1'b1,
    localparam int HI_W      = ROM_AW - PTR_W,
    localparam int LO_W      = TR_BYTE_W,
    localparam int TH_W      = WORD_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [DM_AW-1:0]  dst_i,
    input  logic [PTR_W-1:0]  ptr_lo_i,
    input  logic [HI_W-1:0]   ptr_hi_i,
    input  logic [HI_W-1:0]   pc_hi_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [WORD_W-1:0] rom_data_i,
    output logic              dm_we_o,
    output logic [DM_AW-1:0]  dm_addr_o,
    output logic [LO_W-1:0]   dm_wdata_o,
    output logic [TH_W-1:0]   tbl_hi_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              accept;
    logic [ROM_AW-1:0] addr_n;
    logic [ROM_AW-1:0] addr_q;
    logic [DM_AW-1:0]  dst_q;

    tblrd_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req_i),
        .accept (accept),
        .busy   (busy_o),
        .done   (done_o)
    );

    tblrd_addr_gen #(
        .PTR_W      (PTR_W),
        .ROM_AW     (ROM_AW),
        .USE_HI_PTR (USE_HI_PTR)
    ) u_addr (
        .ptr_lo (ptr_lo_i),
        .ptr_hi (ptr_hi_i),
        .pc_hi  (pc_hi_i),
        .addr   (addr_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            dst_q  <= '0;
        end else if (accept) begin
            addr_q <= addr_n;
            dst_q  <= dst_i;
        end
    end

    tblrd_hi_reg #(
        .WORD_W (WORD_W),
        .LO_W   (LO_W)
    ) u_hi (
        .clk    (clk),
        .rst    (rst),
        .load   (done_o),
        .word   (rom_data_i),
        .tbl_hi (tbl_hi_o)
    );

    assign rom_addr_o = addr_q;
    assign dm_we_o    = done_o;
    assign dm_addr_o  = done_o ? dst_q : '0;
    assign dm_wdata_o = done_o ? rom_data_i[LO_W-1:0] : '0;

    // R4: the address in flight does not move between fetch and write
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(rom_addr_o));
    // R6: the memory write never overlaps a fetch cycle
    a_r6_we_not_busy: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !busy_o);
endmodule

// File: tb/sim_tblrd_unit.sv
`timescale 1ns/100ps
module sim_tblrd_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [7:0]  dst = '0;
    logic [7:0]  plo = '0;
    logic [4:0]  phi = '0;
    logic [4:0]  pch = '0;

    logic [12:0] ra0, ra1;
    logic [15:0] rd0 = '0, rd1 = '0;
    logic        we0, we1, bz0, bz1, dn0, dn1;
    logic [7:0]  da0, da1, wd0, wd1, th0, th1;

    int n_chk = 0;
    int n_fail = 0;
    int phase = 0;

    always #2.5 clk = ~clk;

    tblrd_unit #(.USE_HI_PTR(1'b1)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .dst_i(dst), .ptr_lo_i(plo),
        .ptr_hi_i(phi), .pc_hi_i(pch), .rom_addr_o(ra0), .rom_data_i(rd0),
        .dm_we_o(we0), .dm_addr_o(da0), .dm_wdata_o(wd0), .tbl_hi_o(th0),
        .busy_o(bz0), .done_o(dn0));

    tblrd_unit #(.USE_HI_PTR(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_i(req), .dst_i(dst), .ptr_lo_i(plo),
        .ptr_hi_i(phi), .pc_hi_i(pch), .rom_addr_o(ra1), .rom_data_i(rd1),
        .dm_we_o(we1), .dm_addr_o(da1), .dm_wdata_o(wd1), .tbl_hi_o(th1),
        .busy_o(bz1), .done_o(dn1));

    function automatic logic [15:0] romf(input logic [12:0] a);
        return 16'((32'(a) * 40503 + 4660) ^ (32'(a) << 3));
    endfunction

    // synchronous ROM models, one-cycle latency
    always @(posedge clk) begin
        rd0 <= romf(ra0);
        rd1 <= romf(ra1);
    end

    // behavioural reference: stage 0 idle, 1 fetch, 2 write
    int          m_stage = 0;
    logic [12:0] m_a0 = '0, m_a1 = '0;
    logic [7:0]  m_dst = '0, m_h0 = '0, m_h1 = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_stage <= 0; m_h0 <= '0; m_h1 <= '0;
        end else begin
            if (m_stage == 2) begin
                m_h0 <= romf(m_a0) >> 8;
                m_h1 <= romf(m_a1) >> 8;
            end
            if (m_stage != 1 && req) begin
                m_stage <= 1;
                m_a0 <= {phi, plo};
                m_a1 <= {pch, plo};
                m_dst <= dst;
            end else if (m_stage == 1) begin
                m_stage <= 2;
            end else begin
                m_stage <= 0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_one(input int inst, input logic [12:0] ra, input logic we,
                               input logic [7:0] da, input logic [7:0] wd, input logic [7:0] th,
                               input logic bz, input logic dn,
                               input logic [12:0] ea, input logic [7:0] eh);
        string ta, tb, tw, th_t;
        logic [15:0] w;
        w    = romf(ea);
        ta   = (phase == 2) ? "R4" : (inst == 0 ? "R2" : "R3");
        tb   = (phase == 3) ? "R8" : "R5";
        th_t = (phase == 0) ? "R1" : "R7";
        tw   = (m_stage == 2) ? "R6" : "R9";
        chk(tb, "busy", int'(bz), int'(m_stage == 1));
        chk((phase == 0) ? "R1" : "R6", "done", int'(dn), int'(m_stage == 2));
        chk(tw, "we", int'(we), int'(m_stage == 2));
        chk(tw, "dm_addr", int'(da), (m_stage == 2) ? int'(m_dst) : 0);
        chk(tw, "dm_wdata", int'(wd), (m_stage == 2) ? int'(w[7:0]) : 0);
        chk(th_t, "tbl_hi", int'(th), int'(eh));
        if (m_stage == 1) chk(ta, "rom_addr", int'(ra), int'(ea));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            compare_one(0, ra0, we0, da0, wd0, th0, bz0, dn0, m_a0, m_h0);
            compare_one(1, ra1, we1, da1, wd1, th1, bz1, dn1, m_a1, m_h1);
        end
    end

    task automatic drive(input int req_pct);
        @(negedge clk);
        #1;
        req = (($urandom % 100) < req_pct);
        dst = 8'($urandom);
        plo = 8'($urandom);
        phi = 5'($urandom);
        pch = 5'($urandom);
        if (($urandom % 8) == 0) begin
            plo = 8'hFF; phi = 5'h1F; pch = 5'h00;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        phase = 0;                                  // R1: idle after reset
        repeat (4) drive(0);
        phase = 1;                                  // R2 R3 R6 R7 R9: sparse requests
        repeat (800) drive(30);
        phase = 2;                                  // R4: inputs move during every access
        repeat (800) drive(55);
        phase = 3;                                  // R8 R5: request held high
        for (int i = 0; i < 400; i++) begin
            drive(100);
        end
        phase = 1;
        repeat (6) drive(0);
        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule